// File: doc/BRIEF.md
# Extended VGA Host Register Port Decoder

This block sits on the 8-bit host I/O bus of a VGA-compatible display controller. It takes each port access and decides whether it lands on a register kept here or goes on to the standard sequencer, attribute and palette logic. Registers kept here are the miscellaneous-output register, the graphics-controller index and its extended data registers (indices above 8), and the full CRT-controller index/data pair, vendor extensions included. Accesses to any other port leave the block on a forward strobe, together with the address after remapping. A forwarded read returns the data that the standard logic drives back.

Bit 0 of the miscellaneous-output register chooses between colour and monochrome addressing. While it is clear, accesses in the two CRT pages (0x3B0–0x3BF and 0x3D0–0x3DF) have their address XORed with 0x60 before decoding. The monochrome CRTC ports therefore reach the CRTC, and the colour ones are sent out as monochrome addresses. Readback is combinational in the read-strobe cycle. The configuration register adds a memory-size code to what it returns, an identification register returns a chip-type code, and the extended CRTC space reads as all ones until an unlock bit is set. The CRTC write-protect bit freezes the horizontal timing registers. A one-cycle strobe tells the timing logic to recompute whenever a CRTC register that affects timing actually changes.

Top module: `vgaPortDecoder`

## Requirements
- R1: While miscReg bit 0 is 0, an address whose bits 15:4 are 0x03B or 0x03D is XORed with 0x0060 before decoding and forwarding. While miscReg bit 0 is 1, no address is altered. fwdAddr always carries the decoded (possibly remapped) address.
- R2: A write to port 0x3C2 loads miscReg with the write data. A read of port 0x3CC returns miscReg.
- R3: Port 0x3CE reads and writes the 8-bit graphics index. Port 0x3CF with an index above 8 reads and writes an extended graphics register here. With an index of 8 or below, 0x3CF is forwarded: a write raises fwdWr, and a read raises fwdRd and returns fwdRdData.
- R4: With a graphics index of GFX_REGS (default 16) or above, a write to 0x3CF changes no stored register, and a read of 0x3CF returns 0x00.
- R5: A read of extended graphics register 0x0C returns the stored value with bit 2 set.
- R6: A write to port 0x3D4 stores bits 5:0 of the data as the CRTC index. A read of 0x3D4 returns that index with bits 7:6 zero.
- R7: While CRTC register 0x1E bit 7 is 0, a read of 0x3D5 with CRTC index above 0x18 returns 0xFF. Writes are stored regardless.
- R8: Once unlocked, a read of CRTC register 0x1A returns CHIP_TYPE in bits 7:6 and zero in bits 5:0.
- R9: Once unlocked, a read of CRTC register 0x1E returns the stored value ORed in bits 1:0 with the memory code: 2 when MEM_KB is 1024 or more, 1 when it is 512 or more, 0 otherwise.
- R10: A write to 0x3D5 stores the data in the indexed CRTC register, with one exception. While CRTC register 0x11 bit 7 is 1, writes to indices 0 to 6 change nothing, and a write to index 7 changes only bit 4.
- R11: recalcStb is high for exactly the one cycle after the clock edge that stores a changed value into a CRTC register outside indices 0x0E to 0x10. At all other times it is low.
- R12: Accesses to any other port are forwarded: fwdWr or fwdRd follows ioWr or ioRd in the same cycle, and a read returns fwdRdData. A locally handled access never raises a forward strobe.
- R13: Reset clears every register to zero except miscReg, which resets to 0x01.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| ioAddr | input | 16 | Host port address |
| ioWrData | input | 8 | Host write data |
| ioWr | input | 1 | Write strobe, one access per cycle |
| ioRd | input | 1 | Read strobe |
| ioRdData | output | 8 | Read data, valid in the read-strobe cycle |
| fwdRdData | input | 8 | Read data returned by the standard register logic |
| fwdWr | output | 1 | Write forwarded to the standard register logic |
| fwdRd | output | 1 | Read forwarded to the standard register logic |
| fwdAddr | output | 16 | Address after mono/colour remapping |
| miscReg | output | 8 | Miscellaneous-output register |
| gfxIndex | output | 8 | Graphics-controller index |
| crtcIndex | output | 6 | CRTC index |
| gfxRegsFlat | output | 128 | Graphics register file, register n at bits 8n+7:8n (indices 0–8 stay zero) |
| crtcRegsFlat | output | 512 | CRTC register file, register n at bits 8n+7:8n |
| recalcStb | output | 1 | Timing-recalculation pulse |

## Verification
Both register files drive output ports, so any store that is wrong (a protected register that changes, a dropped extended write, a wrongly masked index) shows up at the edge right after the write. Readback faults show up only in the cycle a read is issued: a lost unlock gate, a missing configuration code or a missing forced bit. The bench therefore reads the lock, identification and configuration registers in every locking state. A wrong remapping or decode shows up at once on the forward strobes and fwdAddr. A wrong change comparison shows up as a recalcStb pulse that is missing or extra one cycle after the write.

// File: rtl/vgaDecPkg.sv
package vgaDecPkg;

  // Ports after mono/colour remapping
  localparam logic [15:0] PORT_MISC_W = 16'h03C2;
  localparam logic [15:0] PORT_MISC_R = 16'h03CC;
  localparam logic [15:0] PORT_GIDX   = 16'h03CE;
  localparam logic [15:0] PORT_GDATA  = 16'h03CF;
  localparam logic [15:0] PORT_CIDX   = 16'h03D4;
  localparam logic [15:0] PORT_CDATA  = 16'h03D5;

  // Pages subject to remapping and the remap mask
  localparam logic [11:0] MONO_PAGE   = 12'h03B;
  localparam logic [11:0] COLOR_PAGE  = 12'h03D;
  localparam logic [15:0] REMAP_XOR   = 16'h0060;

  // Graphics indices at or below this go to the standard logic
  localparam logic [7:0]  GFX_STD_TOP = 8'd8;
  localparam logic [7:0]  GFX_ID_REG  = 8'h0C;

  typedef enum logic [2:0] {
    RD_FWD,
    RD_MISC,
    RD_GIDX,
    RD_GDATA,
    RD_CIDX,
    RD_CDATA
  } rdSel_e;

  // Control-to-datapath strobes
  typedef struct packed {
    logic   miscWr;
    logic   gIdxWr;
    logic   gDataWr;
    logic   cIdxWr;
    logic   cDataWr;
    rdSel_e rdSel;
  } ctlStb_t;

endpackage

// File: rtl/vgaDecCtrl.sv
module vgaDecCtrl
  import vgaDecPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic [15:0] ioAddr,
  input  logic        ioWr,
  input  logic        ioRd,
  input  logic        colorSel,
  input  logic [7:0]  gfxIndex,
  output ctlStb_t     stb,
  output logic        fwdWr,
  output logic        fwdRd,
  output logic [15:0] fwdAddr
);

  logic [15:0] effAddr;
  logic        inWindow;
  logic        gfxExt;
  logic        isMiscW, isMiscR, isGIdx, isGData, isCIdx, isCData;
  logic        wrLocal, rdLocal;

  always_comb begin
    inWindow = (ioAddr[15:4] == MONO_PAGE) || (ioAddr[15:4] == COLOR_PAGE);
    effAddr  = (!colorSel && inWindow) ? (ioAddr ^ REMAP_XOR) : ioAddr;
    gfxExt   = gfxIndex > GFX_STD_TOP;

    isMiscW  = effAddr == PORT_MISC_W;
    isMiscR  = effAddr == PORT_MISC_R;
    isGIdx   = effAddr == PORT_GIDX;
    isGData  = (effAddr == PORT_GDATA) && gfxExt;
    isCIdx   = effAddr == PORT_CIDX;
    isCData  = effAddr == PORT_CDATA;

    wrLocal  = isMiscW | isGIdx | isGData | isCIdx | isCData;
    rdLocal  = isMiscR | isGIdx | isGData | isCIdx | isCData;
  end

  always_comb begin
    stb.miscWr  = ioWr & isMiscW;
    stb.gIdxWr  = ioWr & isGIdx;
    stb.gDataWr = ioWr & isGData;
    stb.cIdxWr  = ioWr & isCIdx;
    stb.cDataWr = ioWr & isCData;
    if (isMiscR)      stb.rdSel = RD_MISC;
    else if (isGIdx)  stb.rdSel = RD_GIDX;
    else if (isGData) stb.rdSel = RD_GDATA;
    else if (isCIdx)  stb.rdSel = RD_CIDX;
    else if (isCData) stb.rdSel = RD_CDATA;
    else              stb.rdSel = RD_FWD;
  end

  assign fwdWr   = ioWr & ~wrLocal;
  assign fwdRd   = ioRd & ~rdLocal;
  assign fwdAddr = effAddr;

  // R12: a write lands on at most one target
  a_r12_one_target: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.miscWr, stb.gIdxWr, stb.gDataWr, stb.cIdxWr, stb.cDataWr, fwdWr}));

  // R12: a read served here never leaves on the forward strobe
  a_r12_rd_excl: assert property (@(posedge clk) disable iff (!rstN)
    (ioRd && stb.rdSel != RD_FWD) |-> !fwdRd);

  // R1: in mono mode the colour CRTC index port leaves as the mono port
  a_r1_mono_redirect: assert property (@(posedge clk) disable iff (!rstN)
    (!colorSel && ioWr && ioAddr == 16'h03D4) |-> (fwdWr && fwdAddr == 16'h03B4));

  // R3: low graphics indices are forwarded
  a_r3_low_gfx_fwd: assert property (@(posedge clk) disable iff (!rstN)
    (ioWr && fwdAddr == PORT_GDATA && gfxIndex <= GFX_STD_TOP) |-> fwdWr);

endmodule

// File: rtl/vgaDecRegs.sv
module vgaDecRegs
  import vgaDecPkg::*;
#(
  parameter int         CRTC_IDX_W = 6,
  parameter int         GFX_REGS   = 16,
  parameter logic [1:0] CHIP_TYPE  = 2'd2,
  parameter logic [1:0] MEM_CODE   = 2'd2
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  ctlStb_t                       stb,
  input  logic [7:0]                    wrData,
  input  logic [7:0]                    fwdRdData,
  output logic [7:0]                    rdData,
  output logic [7:0]                    miscReg,
  output logic [7:0]                    gfxIndex,
  output logic [CRTC_IDX_W-1:0]         crtcIndex,
  output logic [GFX_REGS*8-1:0]         gfxFlat,
  output logic [(1<<CRTC_IDX_W)*8-1:0]  crtcFlat,
  output logic                          recalcStb
);

  localparam int CRTC_REGS = 1 << CRTC_IDX_W;
  localparam int GFX_IDX_W = $clog2(GFX_REGS);

  localparam logic [CRTC_IDX_W-1:0] IDX_PARTIAL  = CRTC_IDX_W'(7);
  localparam logic [CRTC_IDX_W-1:0] IDX_QUIET_LO = CRTC_IDX_W'(14);
  localparam logic [CRTC_IDX_W-1:0] IDX_QUIET_HI = CRTC_IDX_W'(16);
  localparam logic [CRTC_IDX_W-1:0] IDX_PROT     = CRTC_IDX_W'(17);
  localparam logic [CRTC_IDX_W-1:0] IDX_LAST_STD = CRTC_IDX_W'(24);
  localparam logic [CRTC_IDX_W-1:0] IDX_ID       = CRTC_IDX_W'(26);
  localparam logic [CRTC_IDX_W-1:0] IDX_CFG      = CRTC_IDX_W'(30);

  logic [CRTC_REGS-1:0][7:0] crtcReg;
  logic [GFX_REGS-1:0][7:0]  gfxReg;
  logic [GFX_REGS-1:0]       gfxWe;

  logic [7:0] crtcCur, crtcNext, crtcRd, gfxRd;
  logic       protectOn, unlocked, crtcAllow, crtcChanged, quietIdx;
  logic       gfxInRange;

  // ---------------- CRTC write path ----------------
  always_comb begin
    crtcCur     = crtcReg[crtcIndex];
    protectOn   = crtcReg[IDX_PROT][7];
    crtcAllow   = !(protectOn && crtcIndex < IDX_PARTIAL);
    if (protectOn && crtcIndex == IDX_PARTIAL)
      crtcNext = {crtcCur[7:5], wrData[4], crtcCur[3:0]};
    else
      crtcNext = wrData;
    crtcChanged = crtcNext != crtcCur;
    quietIdx    = (crtcIndex >= IDX_QUIET_LO) && (crtcIndex <= IDX_QUIET_HI);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      crtcReg   <= '0;
      crtcIndex <= '0;
      recalcStb <= 1'b0;
    end else begin
      recalcStb <= stb.cDataWr && crtcAllow && crtcChanged && !quietIdx;
      if (stb.cIdxWr)
        crtcIndex <= wrData[CRTC_IDX_W-1:0];
      if (stb.cDataWr && crtcAllow)
        crtcReg[crtcIndex] <= crtcNext;
    end
  end

  // ---------------- Graphics path ----------------
  always_comb gfxInRange = int'(gfxIndex) < GFX_REGS;

  // Only indices above the standard range own storage here
  for (genvar g = 0; g < GFX_REGS; g++) begin : gGfxWe
    if (g > int'(GFX_STD_TOP)) begin : gExt
      assign gfxWe[g] = stb.gDataWr && gfxInRange &&
                        (gfxIndex[GFX_IDX_W-1:0] == GFX_IDX_W'(g));
    end else begin : gStd
      assign gfxWe[g] = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      gfxReg   <= '0;
      gfxIndex <= '0;
    end else begin
      if (stb.gIdxWr)
        gfxIndex <= wrData;
      for (int i = 0; i < GFX_REGS; i++)
        if (gfxWe[i]) gfxReg[i] <= wrData;
    end
  end

  // ---------------- Miscellaneous output ----------------
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           miscReg <= 8'h01;
    else if (stb.miscWr) miscReg <= wrData;
  end

  // ---------------- Readback ----------------
  always_comb begin
    unlocked = crtcReg[IDX_CFG][7];
    if (!unlocked && crtcIndex > IDX_LAST_STD)
      crtcRd = 8'hFF;
    else if (crtcIndex == IDX_ID)
      crtcRd = {CHIP_TYPE, 6'b0};
    else if (crtcIndex == IDX_CFG)
      crtcRd = crtcCur | {6'b0, MEM_CODE};
    else
      crtcRd = crtcCur;

    if (!gfxInRange)
      gfxRd = 8'h00;
    else if (gfxIndex == GFX_ID_REG)
      gfxRd = gfxReg[gfxIndex[GFX_IDX_W-1:0]] | 8'h04;
    else
      gfxRd = gfxReg[gfxIndex[GFX_IDX_W-1:0]];
  end

  always_comb begin
    case (stb.rdSel)
      RD_MISC:  rdData = miscReg;
      RD_GIDX:  rdData = gfxIndex;
      RD_GDATA: rdData = gfxRd;
      RD_CIDX:  rdData = 8'(crtcIndex);
      RD_CDATA: rdData = crtcRd;
      default:  rdData = fwdRdData;
    endcase
  end

  assign crtcFlat = crtcReg;
  assign gfxFlat  = gfxReg;

  // R10: protected low indices keep their value across a write
  a_r10_protect_low: assert property (@(posedge clk) disable iff (!rstN)
    (stb.cDataWr && crtcReg[IDX_PROT][7] && crtcIndex < IDX_PARTIAL)
    |=> crtcReg[$past(crtcIndex)] == $past(crtcReg[crtcIndex]));

  // R10: protected index 7 changes in bit 4 only
  a_r10_protect_seven: assert property (@(posedge clk) disable iff (!rstN)
    (stb.cDataWr && crtcReg[IDX_PROT][7] && crtcIndex == IDX_PARTIAL)
    |=> (crtcReg[IDX_PARTIAL][7:5] == $past(crtcReg[IDX_PARTIAL][7:5])) &&
        (crtcReg[IDX_PARTIAL][3:0] == $past(crtcReg[IDX_PARTIAL][3:0])));

  // R7: locked extended reads return all ones
  a_r7_locked_read: assert property (@(posedge clk) disable iff (!rstN)
    (stb.rdSel == RD_CDATA && !crtcReg[IDX_CFG][7] && crtcIndex > IDX_LAST_STD)
    |-> rdData == 8'hFF);

  // R11: a pulse only follows a CRTC data write
  a_r11_recalc_cause: assert property (@(posedge clk) disable iff (!rstN)
    recalcStb |-> $past(stb.cDataWr));

  // R11: writes in the quiet range never pulse
  a_r11_quiet_range: assert property (@(posedge clk) disable iff (!rstN)
    (stb.cDataWr && crtcIndex >= IDX_QUIET_LO && crtcIndex <= IDX_QUIET_HI)
    |=> !recalcStb);

  // R4: out-of-range graphics writes leave the file alone
  a_r4_gfx_range: assert property (@(posedge clk) disable iff (!rstN)
    (stb.gDataWr && !gfxInRange) |=> $stable(gfxReg));

  // R5: register 0x0C reads with bit 2 set
  a_r5_gfx_id_bit: assert property (@(posedge clk) disable iff (!rstN)
    (stb.rdSel == RD_GDATA && gfxIndex == GFX_ID_REG) |-> rdData[2]);

endmodule

// File: rtl/vgaPortDecoder.sv
module vgaPortDecoder
  import vgaDecPkg::*;
#(
  parameter int         CRTC_IDX_W = 6,
  parameter int         GFX_REGS   = 16,
  parameter logic [1:0] CHIP_TYPE  = 2'd2,
  parameter int         MEM_KB     = 1024
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic [15:0]                   ioAddr,
  input  logic [7:0]                    ioWrData,
  input  logic                          ioWr,
  input  logic                          ioRd,
  output logic [7:0]                    ioRdData,
  input  logic [7:0]                    fwdRdData,
  output logic                          fwdWr,
  output logic                          fwdRd,
  output logic [15:0]                   fwdAddr,
  output logic [7:0]                    miscReg,
  output logic [7:0]                    gfxIndex,
  output logic [CRTC_IDX_W-1:0]         crtcIndex,
  output logic [GFX_REGS*8-1:0]         gfxRegsFlat,
  output logic [(1<<CRTC_IDX_W)*8-1:0]  crtcRegsFlat,
  output logic                          recalcStb
);

  localparam logic [1:0] MEM_CODE = (MEM_KB >= 1024) ? 2'd2 :
                                    (MEM_KB >= 512)  ? 2'd1 : 2'd0;

  ctlStb_t stb;

  vgaDecCtrl i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .ioAddr   (ioAddr),
    .ioWr     (ioWr),
    .ioRd     (ioRd),
    .colorSel (miscReg[0]),
    .gfxIndex (gfxIndex),
    .stb      (stb),
    .fwdWr    (fwdWr),
    .fwdRd    (fwdRd),
    .fwdAddr  (fwdAddr)
  );

  vgaDecRegs #(
    .CRTC_IDX_W (CRTC_IDX_W),
    .GFX_REGS   (GFX_REGS),
    .CHIP_TYPE  (CHIP_TYPE),
    .MEM_CODE   (MEM_CODE)
  ) i_regs (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .wrData    (ioWrData),
    .fwdRdData (fwdRdData),
    .rdData    (ioRdData),
    .miscReg   (miscReg),
    .gfxIndex  (gfxIndex),
    .crtcIndex (crtcIndex),
    .gfxFlat   (gfxRegsFlat),
    .crtcFlat  (crtcRegsFlat),
    .recalcStb (recalcStb)
  );

endmodule

// File: tb/test_vgaPortDecoder.sv
module test_vgaPortDecoder;

  localparam logic [1:0] CHIP = 2'd2;
  localparam int         MEMK = 1024;
  localparam logic [7:0] MEMC = 8'd2;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic [15:0]  ioAddr = '0;
  logic [7:0]   ioWrData = '0;
  logic         ioWr = 1'b0, ioRd = 1'b0;
  logic [7:0]   ioRdData;
  logic [7:0]   fwdRdData = 8'h5A;
  logic         fwdWr, fwdRd;
  logic [15:0]  fwdAddr;
  logic [7:0]   miscReg, gfxIndex;
  logic [5:0]   crtcIndex;
  logic [127:0] gfxRegsFlat;
  logic [511:0] crtcRegsFlat;
  logic         recalcStb;

  vgaPortDecoder #(.CRTC_IDX_W(6), .GFX_REGS(16), .CHIP_TYPE(CHIP), .MEM_KB(MEMK))
  i_vgaPortDecoder (
    .clk(clk), .rstN(rstN), .ioAddr(ioAddr), .ioWrData(ioWrData), .ioWr(ioWr),
    .ioRd(ioRd), .ioRdData(ioRdData), .fwdRdData(fwdRdData), .fwdWr(fwdWr),
    .fwdRd(fwdRd), .fwdAddr(fwdAddr), .miscReg(miscReg), .gfxIndex(gfxIndex),
    .crtcIndex(crtcIndex), .gfxRegsFlat(gfxRegsFlat), .crtcRegsFlat(crtcRegsFlat),
    .recalcStb(recalcStb)
  );

  always #10 clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // ---------------- behavioural model ----------------
  bit [7:0] mCrtc [64];
  bit [7:0] mGfx [16];
  bit [7:0] mMisc, mGi;
  bit [5:0] mCi;
  bit       mRecalc;

  function automatic logic [15:0] remap(input logic [15:0] a);
    if (!mMisc[0] && (a[15:4] == 12'h03B || a[15:4] == 12'h03D)) return a ^ 16'h0060;
    return a;
  endfunction

  function automatic bit isLocal(input logic [15:0] e, input bit rd);
    if (e == 16'h03CE || e == 16'h03D4 || e == 16'h03D5) return 1;
    if (e == 16'h03CF) return mGi > 8;
    if (rd) return e == 16'h03CC;
    return e == 16'h03C2;
  endfunction

  function automatic logic [7:0] expRead(input logic [15:0] e);
    case (e)
      16'h03CC: return mMisc;
      16'h03CE: return mGi;
      16'h03CF: begin
        if (mGi <= 8) return fwdRdData;
        if (mGi >= 16) return 8'h00;
        return mGfx[mGi[3:0]] | ((mGi == 8'h0C) ? 8'h04 : 8'h00);
      end
      16'h03D4: return {2'b00, mCi};
      16'h03D5: begin
        if (!mCrtc[30][7] && mCi > 24) return 8'hFF;
        if (mCi == 26) return {CHIP, 6'b0};
        if (mCi == 30) return mCrtc[30] | MEMC;
        return mCrtc[mCi];
      end
      default: return fwdRdData;
    endcase
  endfunction

  function automatic string readTag(input logic [15:0] a, input logic [15:0] e);
    string t;
    case (e)
      16'h03CC: t = "R2";
      16'h03CE: t = "R3";
      16'h03CF: t = (mGi <= 8) ? "R3" : (mGi >= 16) ? "R4" : (mGi == 8'h0C) ? "R5" : "R3";
      16'h03D4: t = "R6";
      16'h03D5: t = (!mCrtc[30][7] && mCi > 24) ? "R7" : (mCi == 26) ? "R8" :
                    (mCi == 30) ? "R9" : "R10";
      default:  t = "R12";
    endcase
    if (a != e) t = {"R1/", t};
    return t;
  endfunction

  task automatic modelWrite(input logic [15:0] a, input logic [7:0] d);
    logic [15:0] e;
    bit [7:0] nv;
    e = remap(a);
    case (e)
      16'h03C2: mMisc = d;
      16'h03CE: mGi = d;
      16'h03CF: if (mGi > 8 && mGi < 16) mGfx[mGi[3:0]] = d;
      16'h03D4: mCi = d[5:0];
      16'h03D5: begin
        if (!(mCrtc[17][7] && mCi < 7)) begin
          nv = (mCrtc[17][7] && mCi == 7) ? ((mCrtc[7] & 8'hEF) | (d & 8'h10)) : d;
          mRecalc = (nv != mCrtc[mCi]) && !(mCi >= 14 && mCi <= 16);
          mCrtc[mCi] = nv;
        end
      end
      default: ;
    endcase
  endtask

  always @(posedge clk) begin
    if (!rstN) begin
      foreach (mCrtc[i]) mCrtc[i] = 0;
      foreach (mGfx[i]) mGfx[i] = 0;
      mMisc = 8'h01; mGi = 0; mCi = 0; mRecalc = 0;
    end else begin
      mRecalc = 0;
      if (ioWr) modelWrite(ioAddr, ioWrData);
    end
  end

  task automatic chk(input string tag, input string what,
                     input logic [511:0] act, input logic [511:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // Per-cycle comparison, midway between edges
  bit started = 0;
  always begin
    @(negedge clk);
    #5;
    if (rstN && started && !done) begin
      logic [15:0] e;
      logic [511:0] cf;
      logic [127:0] gf;
      e = remap(ioAddr);
      for (int i = 0; i < 64; i++) cf[i*8 +: 8] = mCrtc[i];
      for (int i = 0; i < 16; i++) gf[i*8 +: 8] = mGfx[i];
      chk("R12", "fwdWr", 512'(fwdWr), 512'(ioWr && !isLocal(e, 0)));
      chk("R12", "fwdRd", 512'(fwdRd), 512'(ioRd && !isLocal(e, 1)));
      if (fwdWr || fwdRd) chk("R1", "fwdAddr", 512'(fwdAddr), 512'(e));
      chk("R11", "recalcStb", 512'(recalcStb), 512'(mRecalc));
      chk("R10", "crtcRegsFlat", crtcRegsFlat, cf);
      chk("R4", "gfxRegsFlat", 512'(gfxRegsFlat), 512'(gf));
      chk("R2", "miscReg", 512'(miscReg), 512'(mMisc));
      if (ioRd) chk(readTag(ioAddr, e), "ioRdData", 512'(ioRdData), 512'(expRead(e)));
    end
  end

  task automatic ioWrite(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    ioAddr = a; ioWrData = d; ioWr = 1'b1; ioRd = 1'b0;
    @(negedge clk);
    ioWr = 1'b0;
  endtask

  task automatic ioRead(input logic [15:0] a);
    @(negedge clk);
    ioAddr = a; ioRd = 1'b1; ioWr = 1'b0;
    fwdRdData = fwdRdData + 8'h13;
    @(negedge clk);
    ioRd = 1'b0;
  endtask

  task automatic crtcWr(input logic [5:0] i, input logic [7:0] d);
    ioWrite(16'h03D4, {2'b00, i});
    ioWrite(16'h03D5, d);
  endtask

  task automatic summary;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    #5;
    // R13: reset state
    chk("R13", "miscReg", 512'(miscReg), 512'h01);
    chk("R13", "crtcRegsFlat", crtcRegsFlat, '0);
    chk("R13", "gfxRegsFlat", 512'(gfxRegsFlat), '0);
    chk("R13", "indices", 512'({gfxIndex, 2'b00, crtcIndex}), '0);
    chk("R13", "recalcStb", 512'(recalcStb), '0);
    started = 1;

    ioRead(16'h03CC);                    // R2
    ioWrite(16'h03D4, 8'hFF);            // R6 index masked
    ioRead(16'h03D4);
    crtcWr(6'd0, 8'h5F);                 // R11 change pulses
    ioWrite(16'h03D5, 8'h5F);            // R11 same value, no pulse
    crtcWr(6'd15, 8'h33);                // R11 quiet range
    crtcWr(6'd19, 8'h28);                // R11 index outside quiet range
    crtcWr(6'd25, 8'h44);                // R7 stored while locked
    ioRead(16'h03D5);                    // R7 reads FF
    ioWrite(16'h03D4, 8'd26); ioRead(16'h03D5);
    crtcWr(6'd30, 8'h80);                // unlock
    ioRead(16'h03D5);                    // R9 0x82
    ioWrite(16'h03D4, 8'd26); ioRead(16'h03D5);  // R8
    ioWrite(16'h03D4, 8'd25); ioRead(16'h03D5);  // unlocked extended read
    crtcWr(6'd3, 8'hA5);
    crtcWr(6'd7, 8'h0F);
    crtcWr(6'd17, 8'h80);                // R10 protect on
    crtcWr(6'd3, 8'h11);                 // ignored
    ioRead(16'h03D5);
    crtcWr(6'd7, 8'hFF);                 // only bit 4
    ioRead(16'h03D5);
    crtcWr(6'd17, 8'h00);                // protect off
    crtcWr(6'd2, 8'h77);

    ioWrite(16'h03CE, 8'h0C); ioWrite(16'h03CF, 8'h21); ioRead(16'h03CF); // R5
    ioWrite(16'h03CE, 8'h0A); ioWrite(16'h03CF, 8'h9C); ioRead(16'h03CF); // R3
    ioWrite(16'h03CE, 8'h05); ioWrite(16'h03CF, 8'h40); ioRead(16'h03CF); // R3 forwarded
    ioWrite(16'h03CE, 8'h08); ioWrite(16'h03CF, 8'h41);
    ioWrite(16'h03CE, 8'h20); ioWrite(16'h03CF, 8'hEE); ioRead(16'h03CF); // R4
    ioRead(16'h03CE);
    ioWrite(16'h03C4, 8'h01); ioRead(16'h03C5);  // R12
    ioWrite(16'h03CC, 8'h00); ioRead(16'h03C2);  // R12 direction split

    ioWrite(16'h03C2, 8'h00);            // R1 mono mode
    ioWrite(16'h03B4, 8'h00); ioWrite(16'h03B5, 8'h99); ioRead(16'h03B5);
    ioWrite(16'h03D4, 8'h01); ioRead(16'h03D5); ioRead(16'h03BA);
    ioRead(16'h03DA);
    ioWrite(16'h03C2, 8'h01);
    ioWrite(16'h03B4, 8'h01); ioRead(16'h03BA);

    for (int n = 0; n < 600; n++) begin
      logic [15:0] a;
      case ($urandom_range(0, 10))
        0: a = 16'h03B4; 1: a = 16'h03B5; 2: a = 16'h03D4; 3: a = 16'h03D5;
        4: a = 16'h03CE; 5: a = 16'h03CF; 6: a = 16'h03C2; 7: a = 16'h03CC;
        8: a = 16'h03C4; 9: a = 16'h03BA; default: a = 16'h03D5;
      endcase
      if ($urandom_range(0, 1) == 0) ioWrite(a, 8'($urandom));
      else ioRead(a);
    end

    repeat (2) @(negedge clk);
    done = 1;
    summary();
    $finish;
  end

endmodule